// File: doc/BRIEF.md
# Pulse Duration and Arrival Time Event Recorder

This block turns a level input that is high while an analog pulse sits above threshold into one event record per pulse. A free-running cycle counter gives the arrival time. It restarts from zero when software starts a run or when the external time-zero input is pulsed. When the level input rises, the counter value is captured. While the input stays high, a second counter measures the duration. When the input falls, the duration and the captured time are packed into one 64-bit record, which goes into an on-chip buffer.

Acquisition is gated by a software run bit. A rising edge on that bit starts a run and clears both counters. Readout is switched on by a configuration input. Each stored record is then handed out as two 32-bit words through a valid/acknowledge pair. Flags report that the buffer is empty, that it is full, that a transfer is in progress, and that an event was lost.

Top module: `tot_event_lister`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `buf_empty` is 1 and `buf_full`, `ovf_flag`, `rd_valid` and `rd_busy` are 0. Reset discards all stored records and clears the overflow flag.
- R2: The arrival time is a counter that is 0 in the cycle after an edge sampling a `run_bit` rise or `t0_clr`=1, and grows by one every cycle after that. The time stored for a pulse is the counter value in the cycle before the first edge that samples `tot_in` high.
- R3: The stored duration equals the number of clock edges that sample `tot_in` high during the pulse. With `DUR_W` counter bits it saturates at 2^`DUR_W`-1 instead of wrapping.
- R4: Each pulse produces at most one record, committed by a write strobe that lasts one cycle after the falling edge of `tot_in`. A pulse is recorded only if `run_bit` was already sampled high on the edge before its rise and stayed high until its fall.
- R5: Each record reads out as two words: first the duration, zero-extended to 32 bits, then the arrival time. Records leave in the order they were committed.
- R6: Records leave the buffer only while `rd_cfg_en` is 1. `buf_empty` is 1 exactly when no record is stored.
- R7: `buf_full` is 1 when `DEPTH` records are stored. A record committed while the buffer is full is dropped and sets `ovf_flag`, which stays 1 until reset.
- R8: `rd_busy` is 1 from the cycle after a record is taken from the buffer until the second word is acknowledged. `rd_valid` is never 1 without `rd_busy`.
- R9: When a commit and a readout take from the buffer on the same edge, both succeed. The stored count is unchanged, and the older record still leaves first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the buffer and all flags |
| t0_clr | input | 1 | Clears the arrival-time counter |
| run_bit | input | 1 | Software run control; rising edge starts a run |
| tot_in | input | 1 | Level that is high while the signal is above threshold |
| rd_cfg_en | input | 1 | Readout enable |
| rd_ack | input | 1 | Consumer accepts the word on `rd_data` |
| rd_data | output | 32 | Readout word (duration word, then time word) |
| rd_valid | output | 1 | `rd_data` holds a word |
| buf_empty | output | 1 | No record stored |
| buf_full | output | 1 | Buffer at capacity |
| rd_busy | output | 1 | A record is being transferred out |
| ovf_flag | output | 1 | Sticky: an event was dropped |

## Verification
A commit from the pulse side and a take from the readout side can hit the buffer on the same edge. The bench provokes this with one record already stored and readout disabled. It drops `tot_in`, then raises `rd_cfg_en` one cycle later, so the take and the write strobe meet on the same edge. On the edge after that, `buf_empty` must still be 0, showing that the count stayed at one rather than falling to zero. Draining must then return the older record first and the new one second, with correct field values, and leave the buffer empty.

// File: rtl/tot_lister_pkg.sv
package tot_lister_pkg;

  // Output serializer phases.
  typedef enum logic [1:0] {
    RO_IDLE  = 2'd0,
    RO_FETCH = 2'd1,
    RO_WORD0 = 2'd2,
    RO_WORD1 = 2'd3
  } ro_state_t;

endpackage

// File: rtl/tot_ts_counter.sv
module tot_ts_counter #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  output logic [TS_W-1:0] ts
);

  always_ff @(posedge clk) begin
    if (rst || clr) ts <= '0;
    else            ts <= ts + 1'b1;
  end

endmodule

// File: rtl/tot_pulse_meter.sv
module tot_pulse_meter #(
  parameter int TS_W   = 32,
  parameter int DUR_W  = 32,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_bit,
  input  logic              tot_in,
  input  logic [TS_W-1:0]   ts,
  output logic              run_pulse,
  output logic              ev_wr,
  output logic [2*WORD_W-1:0] ev_rec
);

  localparam logic [DUR_W-1:0] DUR_MAX = {DUR_W{1'b1}};

  logic             run_q;
  logic             tot_q;
  logic             armed;
  logic [TS_W-1:0]  ts_lat;
  logic [DUR_W-1:0] dur;
  logic             tot_rise;
  logic             tot_fall;

  assign run_pulse = run_bit & ~run_q;
  assign tot_rise  = tot_in & ~tot_q;
  assign tot_fall  = ~tot_in & tot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      tot_q  <= 1'b0;
      armed  <= 1'b0;
      ts_lat <= '0;
      dur    <= '0;
      ev_wr  <= 1'b0;
      ev_rec <= '0;
    end else begin
      run_q <= run_bit;
      tot_q <= tot_in;
      ev_wr <= 1'b0;
      if (run_pulse) begin
        // Start of a run: clear the measurement and forget any open pulse.
        dur   <= '0;
        armed <= 1'b0;
      end else if (tot_rise) begin
        ts_lat <= ts;
        dur    <= DUR_W'(1);
        armed  <= run_q;
      end else if (tot_in && tot_q) begin
        if (dur != DUR_MAX) dur <= dur + 1'b1;
        if (!run_bit) armed <= 1'b0;
      end else if (tot_fall) begin
        ev_wr  <= armed & run_bit;
        ev_rec <= {WORD_W'(dur), WORD_W'(ts_lat)};
        armed  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tot_event_fifo.sv
module tot_event_fifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop_req,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full,
  output logic             overflow
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr;
  logic [AW-1:0]    rptr;
  logic [CW-1:0]    count;
  logic             do_push;
  logic             do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CAP);
  assign do_push = push_req & ~full;
  assign do_pop  = pop_req & ~empty;

  // Storage without reset so that it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
    if (do_pop)  rdata     <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
      if (push_req && full) overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/tot_readout.sv
module tot_readout
  import tot_lister_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_en,
  input  logic                fifo_empty,
  input  logic [2*WORD_W-1:0] fifo_rdata,
  input  logic                rd_ack,
  output logic                pop_req,
  output logic [WORD_W-1:0]   rd_data,
  output logic                rd_valid,
  output logic                busy
);

  ro_state_t state;

  assign pop_req = (state == RO_IDLE) && cfg_en && !fifo_empty;
  assign busy    = (state != RO_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RO_IDLE;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      unique case (state)
        RO_IDLE: if (pop_req) state <= RO_FETCH;
        RO_FETCH: begin
          rd_data  <= fifo_rdata[2*WORD_W-1:WORD_W];
          rd_valid <= 1'b1;
          state    <= RO_WORD0;
        end
        RO_WORD0: if (rd_ack) begin
          rd_data <= fifo_rdata[WORD_W-1:0];
          state   <= RO_WORD1;
        end
        RO_WORD1: if (rd_ack) begin
          rd_valid <= 1'b0;
          state    <= RO_IDLE;
        end
        default: state <= RO_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tot_event_lister.sv
module tot_event_lister #(
  parameter int TS_W  = 32,
  parameter int DUR_W = 32,
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        t0_clr,
  input  logic        run_bit,
  input  logic        tot_in,
  input  logic        rd_cfg_en,
  input  logic        rd_ack,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  output logic        buf_empty,
  output logic        buf_full,
  output logic        rd_busy,
  output logic        ovf_flag
);

  localparam int WORD_W = 32;
  localparam int REC_W  = 2 * WORD_W;

  logic [TS_W-1:0]  ts;
  logic             run_pulse;
  logic             ev_wr;
  logic [REC_W-1:0] ev_rec;
  logic [REC_W-1:0] fifo_q;
  logic             ro_pop;

  tot_ts_counter #(.TS_W(TS_W)) u_ts (
    .clk (clk),
    .rst (rst),
    .clr (t0_clr | run_pulse),
    .ts  (ts)
  );

  tot_pulse_meter #(.TS_W(TS_W), .DUR_W(DUR_W), .WORD_W(WORD_W)) u_meter (
    .clk       (clk),
    .rst       (rst),
    .run_bit   (run_bit),
    .tot_in    (tot_in),
    .ts        (ts),
    .run_pulse (run_pulse),
    .ev_wr     (ev_wr),
    .ev_rec    (ev_rec)
  );

  tot_event_fifo #(.WIDTH(REC_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .push_req (ev_wr),
    .wdata    (ev_rec),
    .pop_req  (ro_pop),
    .rdata    (fifo_q),
    .empty    (buf_empty),
    .full     (buf_full),
    .overflow (ovf_flag)
  );

  tot_readout #(.WORD_W(WORD_W)) u_ro (
    .clk        (clk),
    .rst        (rst),
    .cfg_en     (rd_cfg_en),
    .fifo_empty (buf_empty),
    .fifo_rdata (fifo_q),
    .rd_ack     (rd_ack),
    .pop_req    (ro_pop),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .busy       (rd_busy)
  );

endmodule

// File: rtl/tot_lister_chk.sv
module tot_lister_chk (
  input logic clk,
  input logic rst,
  input logic tot_in,
  input logic ev_wr,
  input logic ro_pop,
  input logic rd_cfg_en,
  input logic buf_empty,
  input logic buf_full,
  input logic rd_valid,
  input logic rd_busy,
  input logic ovf_flag
);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (buf_empty && !buf_full && !ovf_flag && !rd_valid && !rd_busy));

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
    ev_wr |=> !ev_wr);

  assert_strobe_after_fall_R4: assert property (@(posedge clk) disable iff (rst)
    ev_wr |-> !$past(tot_in));

  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(buf_full && buf_empty));

  assert_drop_sets_ovf_R7: assert property (@(posedge clk) disable iff (rst)
    (ev_wr && buf_full) |=> ovf_flag);

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);

  assert_valid_in_busy_R8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_busy);

  assert_start_needs_cfg_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_busy) |-> $past(rd_cfg_en));

  assert_pushpop_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (ev_wr && !buf_full && ro_pop) |=> !buf_empty);

endmodule

bind tot_event_lister tot_lister_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .tot_in    (tot_in),
  .ev_wr     (ev_wr),
  .ro_pop    (ro_pop),
  .rd_cfg_en (rd_cfg_en),
  .buf_empty (buf_empty),
  .buf_full  (buf_full),
  .rd_valid  (rd_valid),
  .rd_busy   (rd_busy),
  .ovf_flag  (ovf_flag)
);

// File: tb/sim_tot_event_lister.sv
`timescale 1ns/1ps
module sim_tot_event_lister;

  localparam int DEPTH = 4;
  localparam int DUR_W = 6;
  localparam int DMAX  = (1 << DUR_W) - 1;
  localparam int NVEC  = 4;
  // gap cycles, width cycles
  localparam int VEC [NVEC][2] = '{'{3, 1}, '{2, 7}, '{5, 20}, '{1, 80}};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        t0_clr = 1'b0, run_bit = 1'b0, tot_in = 1'b0;
  logic        rd_cfg_en = 1'b0, rd_ack = 1'b0;
  logic [31:0] rd_data;
  logic        rd_valid, buf_empty, buf_full, rd_busy, ovf_flag;

  int total = 0, bad = 0, cyc = 0, origin = 0;
  int exp_dur [16];
  int exp_ts  [16];
  int n_exp = 0, n_rd = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tot_event_lister #(.TS_W(32), .DUR_W(DUR_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .t0_clr(t0_clr), .run_bit(run_bit), .tot_in(tot_in),
    .rd_cfg_en(rd_cfg_en), .rd_ack(rd_ack), .rd_data(rd_data), .rd_valid(rd_valid),
    .buf_empty(buf_empty), .buf_full(buf_full), .rd_busy(rd_busy), .ovf_flag(ovf_flag)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, longint act, longint expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  // Pulse of 'width' high cycles after 'gap' idle cycles; logs expectation if keep.
  task automatic pulse(int gap, int width, bit keep);
    int rise_c;
    repeat (gap) tick();
    tot_in = 1'b1;
    rise_c = cyc;
    repeat (width) tick();
    tot_in = 1'b0;
    if (keep) begin
      exp_dur[n_exp] = (width > DMAX) ? DMAX : width;
      exp_ts[n_exp]  = rise_c - origin;
      n_exp++;
    end
  endtask

  task automatic read_word(output logic [31:0] w, output bit ok);
    int guard = 0;
    while (!rd_valid && guard < 50) begin tick(); guard++; end
    ok = rd_valid;
    w  = rd_data;
    rd_ack = 1'b1;
    tick();
    rd_ack = 1'b0;
  endtask

  task automatic drain(int n);
    logic [31:0] w0, w1;
    bit ok0, ok1;
    for (int i = 0; i < n; i++) begin
      read_word(w0, ok0);
      check("R8 busy during transfer", rd_busy, 1);
      read_word(w1, ok1);
      check("R6 word available", ok0 & ok1, 1);
      check("R3 R5 duration word first", w0, exp_dur[n_rd]);
      check("R2 R5 time word second", w1, exp_ts[n_rd]);
      n_rd++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    check("R1 empty in reset", buf_empty, 1);
    rst = 1'b0;
    tick();
    check("R1 empty after reset", buf_empty, 1);
    check("R1 full low", buf_full, 0);
    check("R1 ovf low", ovf_flag, 0);
    check("R1 valid/busy low", {rd_valid, rd_busy}, 0);

    // R4: pulse with run off is not recorded
    pulse(2, 5, 1'b0);
    repeat (4) tick();
    check("R4 no record without run", buf_empty, 1);

    // start run
    run_bit = 1'b1;
    origin = cyc + 1;
    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      pulse(VEC[v][0], VEC[v][1], 1'b1);
    end
    repeat (3) tick();
    check("R7 full at depth", buf_full, 1);
    check("R6 nothing leaves while disabled", {rd_valid, rd_busy}, 0);
    check("R7 no overflow yet", ovf_flag, 0);

    // R7: event while full is dropped
    pulse(2, 4, 1'b0);
    repeat (3) tick();
    check("R7 overflow set on drop", ovf_flag, 1);
    check("R7 still full", buf_full, 1);

    rd_cfg_en = 1'b1;
    drain(NVEC);
    repeat (3) tick();
    check("R6 empty after drain", buf_empty, 1);
    check("R8 busy clear after last ack", rd_busy, 0);
    check("R7 overflow sticky", ovf_flag, 1);
    rd_cfg_en = 1'b0;

    // R2: time-zero clear
    repeat (7) tick();
    t0_clr = 1'b1;
    origin = cyc + 1;
    tick();
    t0_clr = 1'b0;
    pulse(4, 9, 1'b1);
    repeat (3) tick();
    check("R6 one stored", buf_empty, 0);

    // R9: commit and take on the same edge
    pulse(3, 6, 1'b1);
    tick();
    rd_cfg_en = 1'b1;
    tick();
    tick();
    check("R9 count kept on push+pop", buf_empty, 0);
    drain(2);
    repeat (3) tick();
    check("R9 empty after both", buf_empty, 1);

    // R1: reset discards records and overflow
    rd_cfg_en = 1'b0;
    pulse(2, 3, 1'b0);
    repeat (3) tick();
    check("R4 stored before reset", buf_empty, 0);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    tick();
    check("R1 reset clears buffer", buf_empty, 1);
    check("R1 reset clears overflow", ovf_flag, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule